// File: doc/BRIEF.md
# Scanline and Frame Sync Timing Generator

This block produces the raster timing for a 262-line pseudo-NTSC frame. A free-running pixel position counter advances once per pixel-clock enable, which a separate clock divider supplies. Each position is decoded into active-low horizontal, composite and vertical sync, a displayed-region flag, a border flag, an active-pixel flag and a one-pixel line interrupt strobe. The sync outputs are open-drain in character. A 0 means the pin is driven low and a 1 means it is released.

A line is built from fixed segments in this order:
- a 64-clock sync pulse,
- a 64-clock gap from sync release to the start of the displayed region,
- a 26-clock leading border,
- the active pixel area (a parameter, 256 clocks by default),
- a 28-clock trailing border,
- an 18-clock gap before the next sync falling edge.

With the defaults the line is 456 clocks. The first nine lines of each frame are serration lines. On these lines vertical sync is held low, and composite sync carries two half-length pulses of 32 clocks: one at the line start and one at mid-line.

All outputs are registered and change only on enabled cycles. Counting pixel positions from 0 after reset, the outputs present after the n-th enabled edge describe position n-1.

Top module: `sync_timing_gen`

## Requirements
- R1: While reset is asserted and after it is released, before any enabled cycle, the outputs are in this state: `hsync_n_o`, `csync_n_o` and `vsync_n_o` are 1 (released), and `disp_o`, `border_o`, `pix_act_o` and `line_irq_o` are 0. The position is line 0, pixel 0.
- R2: `hsync_n_o` is 0 for pixel positions 0..63 of every line and 1 for all other positions.
- R3: `disp_o` is 1 exactly for pixel positions 128..437 on drawn lines. This places its start 64 clocks after sync release.
- R4: On drawn lines, `border_o` is 1 for positions 128..153 (26 clocks) and 438-28..437 (28 clocks). `pix_act_o` is 1 for positions 154..409. The two flags are never 1 together.
- R5: From the last displayed position (437) to the next sync falling edge there are 18 positions (438..455). The line then wraps to position 0.
- R6: `line_irq_o` is 1 for exactly one enabled period on every line, at position 104, which is 40 clocks after sync release.
- R7: A frame has 262 lines (0..261) and then wraps to line 0. Drawn lines are 30..253, where line index 30 is the 31st line. No display flag is set on any other line.
- R8: On lines 0..8, `vsync_n_o` is 0, and `csync_n_o` is 0 for positions 0..31 and 228..259 only. On all other lines `vsync_n_o` is 1.
- R9: On lines 9..261, `csync_n_o` equals `hsync_n_o`.
- R10: A cycle with `pix_en` low changes no output and does not advance the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable from the divider |
| hsync_n_o | output | 1 | Horizontal sync, 0 = driven low |
| csync_n_o | output | 1 | Composite sync with serration pulses, 0 = driven low |
| vsync_n_o | output | 1 | Vertical sync, 0 on serration lines |
| disp_o | output | 1 | Displayed region (borders plus active area) |
| border_o | output | 1 | Inside the leading or trailing border |
| pix_act_o | output | 1 | Inside the active pixel area |
| line_irq_o | output | 1 | One-enable-wide line interrupt strobe |

## Verification
The end of a line and the end of a frame fall on the same enabled edge at position 455 of line 261. On that edge the next output set is the first half-pulse of serration line 0, so the line wrap, the frame wrap and the vertical sync assertion all land together. The bench reaches this edge with a dense enable. Earlier, it crosses a plain line wrap under a sparse enable, so that wrap also coincides with held cycles. An arithmetic model of the segment boundaries predicts every output on every step, and each mismatch is reported against the requirement for the segment it falls in.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

  typedef struct packed {
    logic hs_n;
    logic cs_n;
    logic vs_n;
    logic disp;
    logic border;
    logic pix;
    logic irq;
  } sync_out_t;

  localparam sync_out_t SYNC_OUT_RESET = '{
    hs_n: 1'b1, cs_n: 1'b1, vs_n: 1'b1,
    disp: 1'b0, border: 1'b0, pix: 1'b0, irq: 1'b0
  };

endpackage

// File: rtl/sg_line_ctr.sv
module sg_line_ctr #(
  parameter int LIMIT = 456,
  parameter int W     = $clog2(LIMIT)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         last
);
  localparam logic [W-1:0] LAST_V = W'(LIMIT - 1);

  assign last = (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (en)
      cnt <= last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/sg_decode.sv
module sg_decode
  import sync_gen_pkg::*;
#(
  parameter int HW          = 9,
  parameter int VW          = 9,
  parameter int SYNC_W      = 64,
  parameter int SERR_W      = 32,
  parameter int H_HALF      = 228,
  parameter int DISP_START  = 128,
  parameter int ACT_START   = 154,
  parameter int ACT_END     = 410,
  parameter int DISP_END    = 438,
  parameter int IRQ_POS     = 104,
  parameter int DRAW_FIRST  = 30,
  parameter int DRAW_END    = 254,
  parameter int SERR_LINES  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [HW-1:0] h,
  input  logic [VW-1:0] v,
  output sync_out_t     q
);
  localparam logic [HW-1:0] H_SYNC_END  = HW'(SYNC_W);
  localparam logic [HW-1:0] H_SERR_END  = HW'(SERR_W);
  localparam logic [HW-1:0] H_MID       = HW'(H_HALF);
  localparam logic [HW-1:0] H_MID_END   = HW'(H_HALF + SERR_W);
  localparam logic [HW-1:0] H_DISP_S    = HW'(DISP_START);
  localparam logic [HW-1:0] H_ACT_S     = HW'(ACT_START);
  localparam logic [HW-1:0] H_ACT_E     = HW'(ACT_END);
  localparam logic [HW-1:0] H_DISP_E    = HW'(DISP_END);
  localparam logic [HW-1:0] H_IRQ       = HW'(IRQ_POS);
  localparam logic [VW-1:0] V_DRAW_S    = VW'(DRAW_FIRST);
  localparam logic [VW-1:0] V_DRAW_E    = VW'(DRAW_END);

  logic serr_line;
  logic hs_lo, serr_lo, in_hdisp, in_hact, vdraw;
  sync_out_t nxt;

  generate
    if (SERR_LINES > 0) begin : g_serr
      localparam logic [VW-1:0] V_SERR_E = VW'(SERR_LINES);
      assign serr_line = (v < V_SERR_E);
    end else begin : g_noserr
      assign serr_line = 1'b0;
    end
  endgenerate

  always_comb begin
    hs_lo    = (h < H_SYNC_END);
    serr_lo  = (h < H_SERR_END) || ((h >= H_MID) && (h < H_MID_END));
    in_hdisp = (h >= H_DISP_S) && (h < H_DISP_E);
    in_hact  = (h >= H_ACT_S) && (h < H_ACT_E);
    vdraw    = (v >= V_DRAW_S) && (v < V_DRAW_E);

    nxt.hs_n   = ~hs_lo;
    nxt.cs_n   = serr_line ? ~serr_lo : ~hs_lo;
    nxt.vs_n   = ~serr_line;
    nxt.disp   = vdraw && in_hdisp;
    nxt.pix    = vdraw && in_hact;
    nxt.border = vdraw && in_hdisp && !in_hact;
    nxt.irq    = (h == H_IRQ);
  end

  always_ff @(posedge clk) begin
    if (rst)
      q <= SYNC_OUT_RESET;
    else if (en)
      q <= nxt;
  end
endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen
  import sync_gen_pkg::*;
#(
  parameter int SYNC_W      = 64,
  parameter int GAP_FRONT   = 64,
  parameter int BORDER_L    = 26,
  parameter int ACTIVE_W    = 256,
  parameter int BORDER_R    = 28,
  parameter int GAP_BACK    = 18,
  parameter int IRQ_DLY     = 40,
  parameter int FRAME_LINES = 262,
  parameter int DRAW_FIRST  = 30,
  parameter int DRAW_LINES  = 224,
  parameter int SERR_LINES  = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic pix_en,
  output logic hsync_n_o,
  output logic csync_n_o,
  output logic vsync_n_o,
  output logic disp_o,
  output logic border_o,
  output logic pix_act_o,
  output logic line_irq_o
);
  localparam int DISP_START = SYNC_W + GAP_FRONT;
  localparam int ACT_START  = DISP_START + BORDER_L;
  localparam int ACT_END    = ACT_START + ACTIVE_W;
  localparam int DISP_END   = ACT_END + BORDER_R;
  localparam int H_TOTAL    = DISP_END + GAP_BACK;
  localparam int H_HALF     = H_TOTAL / 2;
  localparam int SERR_W     = SYNC_W / 2;
  localparam int IRQ_POS    = SYNC_W + IRQ_DLY;
  localparam int DRAW_END   = DRAW_FIRST + DRAW_LINES;
  localparam int HW         = $clog2(H_TOTAL);
  localparam int VW         = $clog2(FRAME_LINES);

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_last;
  logic          v_last;
  sync_out_t     q;

  sg_line_ctr #(.LIMIT(H_TOTAL), .W(HW)) u_hctr (
    .clk(clk), .rst(rst), .en(pix_en), .cnt(h_cnt), .last(h_last)
  );

  sg_line_ctr #(.LIMIT(FRAME_LINES), .W(VW)) u_vctr (
    .clk(clk), .rst(rst), .en(pix_en && h_last), .cnt(v_cnt), .last(v_last)
  );

  sg_decode #(
    .HW(HW), .VW(VW), .SYNC_W(SYNC_W), .SERR_W(SERR_W), .H_HALF(H_HALF),
    .DISP_START(DISP_START), .ACT_START(ACT_START), .ACT_END(ACT_END),
    .DISP_END(DISP_END), .IRQ_POS(IRQ_POS), .DRAW_FIRST(DRAW_FIRST),
    .DRAW_END(DRAW_END), .SERR_LINES(SERR_LINES)
  ) u_dec (
    .clk(clk), .rst(rst), .en(pix_en), .h(h_cnt), .v(v_cnt), .q(q)
  );

  assign hsync_n_o  = q.hs_n;
  assign csync_n_o  = q.cs_n;
  assign vsync_n_o  = q.vs_n;
  assign disp_o     = q.disp;
  assign border_o   = q.border;
  assign pix_act_o  = q.pix;
  assign line_irq_o = q.irq;
endmodule

// File: rtl/sync_gen_chk.sv
module sync_gen_chk #(
  parameter int HW      = 9,
  parameter int VW      = 9,
  parameter int H_TOTAL = 456,
  parameter int V_TOTAL = 262
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt,
  input logic          hsync_n_o,
  input logic          csync_n_o,
  input logic          vsync_n_o,
  input logic          disp_o,
  input logic          border_o,
  input logic          pix_act_o,
  input logic          line_irq_o
);
  localparam logic [HW-1:0] H_LIM = HW'(H_TOTAL);
  localparam logic [VW-1:0] V_LIM = VW'(V_TOTAL);

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    (line_irq_o && pix_en) |=> !line_irq_o);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(hsync_n_o) && $stable(csync_n_o) && $stable(vsync_n_o)
                 && $stable(disp_o) && $stable(line_irq_o)));

  // R4
  pix_border_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pix_act_o && border_o));

  // R3
  pix_in_disp_chk: assert property (@(posedge clk) disable iff (rst)
    pix_act_o |-> disp_o);

  // R8
  vs_no_disp_chk: assert property (@(posedge clk) disable iff (rst)
    !vsync_n_o |-> !disp_o);

  // R2
  hfall_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n_o) |-> !csync_n_o);

  // R7
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    (h_cnt < H_LIM) && (v_cnt < V_LIM));
endmodule

bind sync_timing_gen sync_gen_chk #(
  .HW(HW), .VW(VW), .H_TOTAL(H_TOTAL), .V_TOTAL(FRAME_LINES)
) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .h_cnt(h_cnt), .v_cnt(v_cnt),
  .hsync_n_o(hsync_n_o), .csync_n_o(csync_n_o), .vsync_n_o(vsync_n_o),
  .disp_o(disp_o), .border_o(border_o), .pix_act_o(pix_act_o),
  .line_irq_o(line_irq_o)
);

// File: tb/tb_sync_timing_gen.sv
module tb_sync_timing_gen;
  localparam int CLK_P   = 10;
  localparam int H_TOT   = 64 + 64 + 26 + 256 + 28 + 18;
  localparam int V_TOT   = 262;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0;
  logic hsync_n_o, csync_n_o, vsync_n_o, disp_o, border_o, pix_act_o, line_irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int hp = 0;
  int vp = 0;
  logic [6:0] expv = 7'b1110000;
  string tagv [7];

  always #(CLK_P/2) clk = ~clk;

  sync_timing_gen dut (
    .clk(clk), .rst(rst), .pix_en(pix_en),
    .hsync_n_o(hsync_n_o), .csync_n_o(csync_n_o), .vsync_n_o(vsync_n_o),
    .disp_o(disp_o), .border_o(border_o), .pix_act_o(pix_act_o),
    .line_irq_o(line_irq_o)
  );

  function automatic logic [6:0] model(int h, int v);
    logic hs, cs, vs, dsp, brd, px, irq, draw, serr;
    draw = (v >= 30) && (v < 254);
    serr = (v < 9);
    hs   = !(h < 64);
    cs   = serr ? !((h < 32) || (h >= 228 && h < 260)) : hs;
    vs   = !serr;
    dsp  = draw && (h >= 128) && (h < 438);
    px   = draw && (h >= 154) && (h < 410);
    brd  = draw && (((h >= 128) && (h < 154)) || ((h >= 410) && (h < 438)));
    irq  = (h == 104);
    return {hs, cs, vs, dsp, brd, px, irq};
  endfunction

  task automatic chk(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s h=%0d v=%0d actual=%b expected=%b", tag, nm, hp, vp, act, exp);
    end
  endtask

  task automatic step(bit e);
    logic [6:0] a;
    @(negedge clk);
    pix_en = e;
    @(posedge clk);
    #1;
    if (e) begin
      expv = model(hp, vp);
      tagv[0] = (hp >= 438) ? "R5" : "R2";
      tagv[1] = (vp < 9) ? "R8" : "R9";
      tagv[2] = "R8";
      tagv[3] = ((vp < 30) || (vp >= 254)) ? "R7" : "R3";
      tagv[4] = "R4";
      tagv[5] = "R4";
      tagv[6] = "R6";
      hp++;
      if (hp == H_TOT) begin
        hp = 0;
        vp = (vp == V_TOT - 1) ? 0 : vp + 1;
      end
    end else begin
      for (int i = 0; i < 7; i++) tagv[i] = "R10";
    end
    a = {hsync_n_o, csync_n_o, vsync_n_o, disp_o, border_o, pix_act_o, line_irq_o};
    chk(tagv[0], "hsync_n", a[6], expv[6]);
    chk(tagv[1], "csync_n", a[5], expv[5]);
    chk(tagv[2], "vsync_n", a[4], expv[4]);
    chk(tagv[3], "disp",    a[3], expv[3]);
    chk(tagv[4], "border",  a[2], expv[2]);
    chk(tagv[5], "pix_act", a[1], expv[1]);
    chk(tagv[6], "irq",     a[0], expv[0]);
  endtask

  initial begin
    #(CLK_P * 250000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    pix_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    pix_en = 1'b0;
    #1;
    // R1: released syncs, flags low
    chk("R1", "hsync_n", hsync_n_o, 1'b1);
    chk("R1", "csync_n", csync_n_o, 1'b1);
    chk("R1", "vsync_n", vsync_n_o, 1'b1);
    chk("R1", "disp",    disp_o,    1'b0);
    chk("R1", "border",  border_o,  1'b0);
    chk("R1", "pix_act", pix_act_o, 1'b0);
    chk("R1", "irq",     line_irq_o, 1'b0);
    // R10: sparse enable across the first line wrap
    for (int i = 0; i < 1500; i++) step((i % 3) == 0);
    // dense enable through the rest of the frame and across the frame wrap
    while (!(vp == 0 && hp == 0)) step(1'b1);
    step(1'b1);
    // R7: wrapped to line 0, serration line
    chk("R7", "vsync_n_after_wrap", vsync_n_o, 1'b0);
    chk("R7", "csync_n_after_wrap", csync_n_o, 1'b0);
    for (int i = 0; i < 600; i++) step(1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule